// File: doc/BRIEF.md
# Cable Identity Responder for Structured Vendor-Defined Messages

This block sits on the cable side of a configuration-channel link, behind a protocol layer that has already stripped framing and CRC from an incoming data message addressed to the cable. The protocol layer hands over the first 32-bit object of that message, the vendor-defined message header, with a one-cycle valid strobe. The responder classifies the header. For an identity query it streams back a response header and the cable's identity objects, taken from a register block. For any other structured command it sends a single refusal header. Requests that are not addressed to it as a responder get no answer.

Identity objects come from four 32-bit configuration inputs. The responder forces the reserved fields of the identity header and the certification object to zero, and it appends the cable object only when the identity header declares a passive or active cable. The response leaves as a valid/ready stream of 32-bit words with a last flag. The total object count is presented with every word, so the framing logic can size the message before the first word is taken. A fresh actionable request always restarts the stream, which lets a command sequence be interrupted at any point.

Top module: `vdm_id_responder`

## Requirements
- R1: While reset is asserted and after its release with no request, `rsp_valid` is low.
- R2: A request with bit 15 = 1 (structured), bits [7:6] = 00 (initiator) and bits [4:0] = 1 (identity query) produces, on the next cycle, a first word equal to {16'hFF00, 1'b1, 2'b00, 2'b00, 3'b000, 2'b01, 1'b0, 5'd1}, i.e. the PD SID with an ACK command type (01).
- R3: An identity response streams, in order, the response header, the identity header, the certification object, the product object and, when present, the cable object; `rsp_last` is high on the final word only, and `rsp_valid` drops after that word is accepted.
- R4: The streamed identity header equals the configured one with bits [25:16] cleared; the certification object equals the configured one with bits [31:20] cleared; the product and cable objects pass unchanged.
- R5: The cable object is sent, and `rsp_count` is 5, exactly when the identity header's product-type field [29:27] is 011 (passive cable) or 100 (active cable); otherwise `rsp_count` is 4.
- R6: A structured initiator request with any command other than 1 yields a single word {request[31:16], 1'b1, 4'b0000, request[10:8], 2'b10, 1'b0, request[4:0]} (NAK, type 10) with `rsp_count` = 1 and `rsp_last` high.
- R7: A request with bit 15 = 0 (unstructured) produces no response.
- R8: A structured request whose command type [7:6] is 01, 10 or 11 produces no response.
- R9: The version field [14:13], the reserved bits [12:11] and bit 5 of a request do not affect the response; the response header carries zero in all of them.
- R10: While `rsp_ready` is low, the presented word, `rsp_last` and `rsp_count` hold.
- R11: An actionable request that arrives while a response is streaming abandons it; the next cycle presents word 0 of the new response.
- R12: A non-actionable request that arrives during a stream leaves the stream undisturbed.
- R13: `rsp_count` stays constant for a whole response and equals the number of words sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle strobe: `req_word` holds a received message header |
| req_word | input | 32 | Received vendor-defined message header |
| cfg_id_header | input | 32 | Identity header from the register block |
| cfg_cert_vdo | input | 32 | Certification status object from the register block |
| cfg_product_vdo | input | 32 | Product object from the register block |
| cfg_cable_vdo | input | 32 | Cable object from the register block |
| rsp_valid | output | 1 | Response word is valid |
| rsp_ready | input | 1 | Downstream accepts the response word |
| rsp_word | output | 32 | Current response word |
| rsp_last | output | 1 | Current word is the final one of the response |
| rsp_count | output | 3 | Number of words in the current response |

## Verification
A table of requests is run against the responder: identity queries with passive-cable, active-cable and non-cable identity headers tell a five-word reply from a four-word one and expose any missing masking of reserved fields. The same query with junk in the version and reserved bits and a foreign SVID shows that only the meaningful fields steer the reply. Several non-identity commands, with differing SVIDs and object positions, separate the echoed NAK fields. Unstructured and responder-typed headers must leave the output silent. Directed sequences then stall the stream, interrupt it with a new query, and inject an ignorable header mid-stream, to tell a restart apart from a hold.

// File: rtl/vdm_id_pkg.sv
package vdm_id_pkg;
  localparam int WORD_W  = 32;
  localparam int MAX_OBJ = 5;
  localparam int CNT_W   = $clog2(MAX_OBJ + 1);
  localparam int IDX_W   = $clog2(MAX_OBJ);

  localparam logic [15:0] PD_SID      = 16'hFF00;
  localparam logic [4:0]  CMD_DISC_ID = 5'd1;
  localparam logic [2:0]  PT_PASSIVE  = 3'b011;
  localparam logic [2:0]  PT_ACTIVE   = 3'b100;

  localparam logic [WORD_W-1:0] ID_KEEP   = 32'hFC00_FFFF;
  localparam logic [WORD_W-1:0] CERT_KEEP = 32'h000F_FFFF;

  typedef enum logic [1:0] {
    CT_INIT = 2'b00,
    CT_ACK  = 2'b01,
    CT_NAK  = 2'b10,
    CT_BUSY = 2'b11
  } cmd_type_e;

  typedef struct packed {
    logic [15:0] svid;
    logic [2:0]  obj_pos;
    logic [4:0]  cmd;
  } req_fields_t;
endpackage

// File: rtl/vdm_hdr_decode.sv
module vdm_hdr_decode
  import vdm_id_pkg::*;
(
  input  logic [WORD_W-1:0] hdr_i,
  output req_fields_t       fields_o,
  output logic              answer_o,
  output logic              disc_id_o
);
  cmd_type_e ctype;

  always_comb begin
    ctype            = cmd_type_e'(hdr_i[7:6]);
    fields_o.svid    = hdr_i[31:16];
    fields_o.obj_pos = hdr_i[10:8];
    fields_o.cmd     = hdr_i[4:0];
    answer_o         = hdr_i[15] && (ctype == CT_INIT);
    disc_id_o        = (hdr_i[4:0] == CMD_DISC_ID);
  end
endmodule

// File: rtl/vdm_obj_mux.sv
module vdm_obj_mux
  import vdm_id_pkg::*;
(
  input  logic              ack_i,
  input  req_fields_t       fields_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] id_hdr_i,
  input  logic [WORD_W-1:0] cert_i,
  input  logic [WORD_W-1:0] prod_i,
  input  logic [WORD_W-1:0] cable_i,
  output logic              cable_o,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] hdr_word;

  always_comb begin
    cable_o = (id_hdr_i[29:27] == PT_PASSIVE) || (id_hdr_i[29:27] == PT_ACTIVE);
    if (ack_i) begin
      hdr_word = {PD_SID, 1'b1, 2'b00, 2'b00, 3'b000, CT_ACK, 1'b0, CMD_DISC_ID};
    end else begin
      hdr_word = {fields_i.svid, 1'b1, 2'b00, 2'b00, fields_i.obj_pos, CT_NAK, 1'b0, fields_i.cmd};
    end
    case (idx_i)
      IDX_W'(0): word_o = hdr_word;
      IDX_W'(1): word_o = id_hdr_i & ID_KEEP;
      IDX_W'(2): word_o = cert_i & CERT_KEEP;
      IDX_W'(3): word_o = prod_i;
      IDX_W'(4): word_o = cable_i;
      default:   word_o = '0;
    endcase
  end
endmodule

// File: rtl/vdm_rsp_seq.sv
module vdm_rsp_seq
  import vdm_id_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o,
  output logic [CNT_W-1:0] count_o
);
  logic             valid_q, valid_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] count_q;
  logic             last_w;

  assign last_w = valid_q && ((CNT_W'(idx_q) + CNT_W'(1)) == count_q);

  always_comb begin
    valid_d = valid_q;
    idx_d   = idx_q;
    if (load_i) begin
      valid_d = 1'b1;
      idx_d   = '0;
    end else if (valid_q && ready_i) begin
      if (last_w) begin
        valid_d = 1'b0;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      count_q <= '0;
    end else begin
      valid_q <= valid_d;
      idx_q   <= idx_d;
      if (load_i) begin
        count_q <= count_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign idx_o   = idx_q;
  assign last_o  = last_w;
  assign count_o = count_q;
endmodule

// File: rtl/vdm_id_responder.sv
module vdm_id_responder
  import vdm_id_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [WORD_W-1:0] req_word,
  input  logic [WORD_W-1:0] cfg_id_header,
  input  logic [WORD_W-1:0] cfg_cert_vdo,
  input  logic [WORD_W-1:0] cfg_product_vdo,
  input  logic [WORD_W-1:0] cfg_cable_vdo,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_word,
  output logic              rsp_last,
  output logic [CNT_W-1:0]  rsp_count
);
  req_fields_t      dec_fields, fields_q;
  logic             dec_answer, dec_disc_id;
  logic             ack_q;
  logic             load;
  logic             has_cable;
  logic [CNT_W-1:0] count_d;
  logic [IDX_W-1:0] idx;

  vdm_hdr_decode u_dec (
    .hdr_i     (req_word),
    .fields_o  (dec_fields),
    .answer_o  (dec_answer),
    .disc_id_o (dec_disc_id)
  );

  assign load = req_valid && dec_answer;

  always_comb begin
    if (!dec_disc_id) begin
      count_d = CNT_W'(1);
    end else if (has_cable) begin
      count_d = CNT_W'(MAX_OBJ);
    end else begin
      count_d = CNT_W'(MAX_OBJ - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= '0;
      ack_q    <= 1'b0;
    end else if (load) begin
      fields_q <= dec_fields;
      ack_q    <= dec_disc_id;
    end
  end

  vdm_rsp_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .count_i (count_d),
    .ready_i (rsp_ready),
    .valid_o (rsp_valid),
    .idx_o   (idx),
    .last_o  (rsp_last),
    .count_o (rsp_count)
  );

  vdm_obj_mux u_mux (
    .ack_i    (ack_q),
    .fields_i (fields_q),
    .idx_i    (idx),
    .id_hdr_i (cfg_id_header),
    .cert_i   (cfg_cert_vdo),
    .prod_i   (cfg_product_vdo),
    .cable_i  (cfg_cable_vdo),
    .cable_o  (has_cable),
    .word_o   (rsp_word)
  );
endmodule

// File: rtl/vdm_id_responder_chk.sv
module vdm_id_responder_chk
  import vdm_id_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [WORD_W-1:0] req_word,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_W-1:0] rsp_word,
  input logic              rsp_last,
  input logic [CNT_W-1:0]  rsp_count
);
  logic start;
  assign start = req_valid && req_word[15] && (req_word[7:6] == 2'b00);

  a_r2_ack_header: assert property (@(posedge clk) disable iff (!rst_n)
    start && (req_word[4:0] == 5'd1) |=>
      rsp_valid && (rsp_word[31:16] == 16'hFF00) && rsp_word[15] &&
      (rsp_word[7:6] == 2'b01) && (rsp_word[4:0] == 5'd1));

  a_r6_nak_single: assert property (@(posedge clk) disable iff (!rst_n)
    start && (req_word[4:0] != 5'd1) |=>
      rsp_valid && rsp_last && (rsp_count == CNT_W'(1)) &&
      (rsp_word[7:6] == 2'b10) && (rsp_word[4:0] == $past(req_word[4:0])));

  // R7 and R8: a header that is not a structured initiator stays silent
  a_r7_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid && req_valid && !start |=> !rsp_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready && !start |=>
      rsp_valid && $stable(rsp_last) && $stable(rsp_count));

  a_r3_end: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && rsp_last && !start |=> !rsp_valid);

  a_r5_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_count == CNT_W'(1)) || (rsp_count == CNT_W'(4)) ||
                  (rsp_count == CNT_W'(5)));

  a_r13_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !start |=> !rsp_valid || $stable(rsp_count));
endmodule

bind vdm_id_responder vdm_id_responder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_word  (req_word),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_word  (rsp_word),
  .rsp_last  (rsp_last),
  .rsp_count (rsp_count)
);

// File: tb/vdm_id_responder_tb.sv
module vdm_id_responder_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CERT  = 32'hABC1_2345;
  localparam logic [31:0] PROD  = 32'h5A5A_1234;
  localparam logic [31:0] CABLE = 32'h1234_5678;
  localparam logic [31:0] ID_PASSIVE = 32'h19AB_1234;
  localparam logic [31:0] ID_ACTIVE  = 32'hE3CD_29C4;
  localparam logic [31:0] ID_PERIPH  = 32'h5400_BEEF;
  localparam logic [31:0] RQ_DI      = 32'hFF00_8001;
  localparam int NVEC = 10;
  // {request header, identity header}
  localparam logic [63:0] VEC [NVEC] = '{
    {RQ_DI,          ID_PASSIVE},  // R2 R3 R4 R5 passive cable
    {RQ_DI,          ID_ACTIVE},   // R5 active cable
    {RQ_DI,          ID_PERIPH},   // R5 not a cable
    {32'h1234_F821,  ID_PASSIVE},  // R9 junk version/reserved bits
    {32'hFF00_8302,  ID_PASSIVE},  // R6 discover SVIDs
    {32'h8087_8104,  ID_ACTIVE},   // R6 enter mode
    {32'hABCD_8011,  ID_PERIPH},   // R6 SVID-specific
    {32'hFF00_0001,  ID_PASSIVE},  // R7 unstructured
    {32'hFF00_8041,  ID_PASSIVE},  // R8 ACK type
    {32'hFF00_80C1,  ID_PASSIVE}   // R8 BUSY type
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_word;
  logic [31:0] cfg_id_header;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [31:0] rsp_word;
  logic        rsp_last;
  logic [2:0]  rsp_count;
  int          errors;
  int          checks;

  vdm_id_responder u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_word        (req_word),
    .cfg_id_header   (cfg_id_header),
    .cfg_cert_vdo    (CERT),
    .cfg_product_vdo (PROD),
    .cfg_cable_vdo   (CABLE),
    .rsp_valid       (rsp_valid),
    .rsp_ready       (rsp_ready),
    .rsp_word        (rsp_word),
    .rsp_last        (rsp_last),
    .rsp_count       (rsp_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int exp_count(input logic [31:0] rq, input logic [31:0] idh);
    if (!rq[15] || rq[7:6] != 2'b00) return 0;
    if (rq[4:0] != 5'd1) return 1;
    if (idh[29:27] == 3'b011 || idh[29:27] == 3'b100) return 5;
    return 4;
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] rq, input logic [31:0] idh, input int i);
    case (i)
      0: return (rq[4:0] == 5'd1) ? 32'hFF00_8041
                                  : {rq[31:16], 1'b1, 4'b0000, rq[10:8], 2'b10, 1'b0, rq[4:0]};
      1: return {idh[31:26], 10'd0, idh[15:0]};
      2: return {12'd0, CERT[19:0]};
      3: return PROD;
      default: return CABLE;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called just after a falling edge
  task automatic send_req(input logic [31:0] w);
    req_valid = 1'b1;
    req_word  = w;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic collect(input logic [31:0] rq, input logic [31:0] idh, input int from, input int upto, input string tag);
    int n;
    n = exp_count(rq, idh);
    for (int i = from; i < upto; i++) begin
      logic [31:0] e;
      e = exp_word(rq, idh, i);
      check(rsp_valid && rsp_word == e && rsp_last == (i == n - 1) && int'(rsp_count) == n,
            $sformatf("%s word%0d (R3 R4 R13) cnt=%0d last=%0b", tag, i, rsp_count, rsp_last),
            rsp_word, e);
      @(negedge clk);
    end
    if (upto == n) check(!rsp_valid, {tag, " end of stream R3"}, {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    errors = 0;
    checks = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_word = '0;
    rsp_ready = 1'b1;
    cfg_id_header = ID_PASSIVE;
    repeat (3) @(negedge clk);
    check(!rsp_valid, "R1 valid during reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!rsp_valid, "R1 idle after reset", {31'd0, rsp_valid}, 32'd0);

    for (int k = 0; k < NVEC; k++) begin
      logic [31:0] rq;
      logic [31:0] idh;
      int n;
      rq  = VEC[k][63:32];
      idh = VEC[k][31:0];
      n   = exp_count(rq, idh);
      cfg_id_header = idh;
      @(negedge clk);
      send_req(rq);
      if (n == 0) begin
        for (int c = 0; c < 3; c++) begin
          check(!rsp_valid, $sformatf("R7 R8 silent vec%0d", k), {31'd0, rsp_valid}, 32'd0);
          @(negedge clk);
        end
      end else begin
        collect(rq, idh, 0, n, $sformatf("R2 R5 R6 R9 vec%0d", k));
      end
    end

    // R10 backpressure
    cfg_id_header = ID_ACTIVE;
    rsp_ready = 1'b0;
    send_req(RQ_DI);
    for (int c = 0; c < 3; c++) begin
      check(rsp_valid && rsp_word == 32'hFF00_8041 && rsp_count == 3'd5 && !rsp_last,
            "R10 hold under stall", rsp_word, 32'hFF00_8041);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    collect(RQ_DI, ID_ACTIVE, 0, 5, "R10 drain");

    // R11 interrupt with a new actionable request
    send_req(RQ_DI);
    collect(RQ_DI, ID_ACTIVE, 0, 2, "R11 first part");
    send_req(32'hFF00_8303);
    collect(32'hFF00_8303, ID_ACTIVE, 0, 1, "R11 restarted");

    // R12 ignorable request mid-stream
    cfg_id_header = ID_PERIPH;
    send_req(RQ_DI);
    collect(RQ_DI, ID_PERIPH, 0, 1, "R12 before");
    rsp_ready = 1'b0;
    send_req(32'hFF00_0003);
    rsp_ready = 1'b1;
    collect(RQ_DI, ID_PERIPH, 1, 4, "R12 after");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule